// File: doc/BRIEF.md
# System-Management Interrupt Status Collector

This block gathers system-management interrupt (SMI) causes from six sources and reports them through two levels of status. The sources are two general-purpose timer expirations, three address traps for user-defined devices, and one configuration-cycle trap. The configuration-cycle trap is itself the OR of six per-function trap inputs. Every timer, every device trap and every function trap has its own enable bit. An enabled event sets a sticky flag in the second-level status register. Any set flag raises a summary bit in a top-level status register, and that summary bit drives the SMI output as a level.

Handler software reads the status through a two-address read port. Address 0 is the clearing view. It returns the flags and then clears the flags, the summary bit and SMI. Address 1 is a mirror. It returns the same flags and leaves all state untouched, so SMI stays asserted. Read data is registered and appears one cycle after the read strobe. Writes to either address have no effect.

Top module: `smi_status_agg`

## Requirements
- R1: The second-level flag layout is fixed. Bit 0 is timer 1 expired, bit 1 is timer 2 expired, bits 2, 3 and 4 are device traps 1, 2 and 3, and bit 5 is the configuration-cycle trap. Bits 15 to 6 of read data are always 0.
- R2: A source pulse with its enable at 1 sets its flag at the next clock edge. The flag stays set until a clearing read.
- R3: A source pulse with its enable at 0 sets no flag and does not raise SMI.
- R4: Flag bit 5 is set when at least one of the six function-trap inputs is high in the same cycle as its own enable bit.
- R5: In top_stat_o, bit 9 is 1 exactly when any second-level flag is 1, and every other bit is 0. smi_o equals that bit.
- R6: A read at address 0 returns the pre-read flags on rd_data_o in the following cycle. The same read clears the flags, the summary bit and smi_o.
- R7: A read at address 1 returns the same flags on rd_data_o in the following cycle and clears nothing.
- R8: An enabled event that coincides with a clearing read is missing from that read's data. It is still latched afterwards, with the summary bit and smi_o set.
- R9: A write strobe at either address, with any data, changes no flag, no summary bit and no output.
- R10: Synchronous reset sets the flags, top_stat_o, smi_o and rd_data_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_expire_i | input | 2 | Timer expiration pulses (timer 1 on bit 0) |
| tmr_en_i | input | 2 | Per-timer SMI enables |
| dev_trap_i | input | 3 | User-defined device trap pulses (device 1 on bit 0) |
| dev_en_i | input | 3 | Per-device SMI enables |
| func_trap_i | input | 6 | Per-function configuration-cycle trap pulses |
| func_en_i | input | 6 | Per-function trap enables |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (ignored) |
| addr_i | input | 1 | 0 = clearing view, 1 = mirror view |
| wr_data_i | input | 16 | Write data (ignored) |
| rd_data_o | output | 16 | Registered read data |
| top_stat_o | output | 16 | Top-level status, summary on bit 9 |
| smi_o | output | 1 | SMI request level |

## Verification
Two functions can fall in the same cycle: a clearing read, and a new enabled event that sets a flag. The bench provokes this directly by raising sources during the address-0 read strobe. It also does so throughout a long pseudo-random phase in which reads, writes and events overlap freely. A cycle-level model computed in the bench judges the result. The returned word must hold only the flags from before the read, and the flags, summary bit and SMI that remain must be exactly the coinciding events.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
  localparam int DATA_W   = 16;
  localparam int N_TMR    = 2;
  localparam int N_DEV    = 3;
  localparam int N_FUNC   = 6;
  localparam int N_SRC    = N_TMR + N_DEV + 1;
  localparam int CFG_BIT  = N_TMR + N_DEV;
  localparam int SUM_BIT  = 9;
  localparam logic ADDR_CLR = 1'b0;
  localparam logic ADDR_MIR = 1'b1;
endpackage

// File: rtl/smi_src_gate.sv
module smi_src_gate #(
  parameter int N_TMR  = 2,
  parameter int N_DEV  = 3,
  parameter int N_FUNC = 6,
  localparam int N_SRC = N_TMR + N_DEV + 1
) (
  input  logic [N_TMR-1:0]  tmr_expire_i,
  input  logic [N_TMR-1:0]  tmr_en_i,
  input  logic [N_DEV-1:0]  dev_trap_i,
  input  logic [N_DEV-1:0]  dev_en_i,
  input  logic [N_FUNC-1:0] func_trap_i,
  input  logic [N_FUNC-1:0] func_en_i,
  output logic [N_SRC-1:0]  ev_o
);
  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    assign ev_o[t] = tmr_expire_i[t] & tmr_en_i[t];
  end
  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    assign ev_o[N_TMR+d] = dev_trap_i[d] & dev_en_i[d];
  end
  assign ev_o[N_SRC-1] = |(func_trap_i & func_en_i);
endmodule

// File: rtl/smi_flag_reg.sv
module smi_flag_reg #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] ev_i,
  input  logic             clr_i,
  output logic [N_SRC-1:0] flags_o
);
  logic [N_SRC-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (clr_i ? '0 : flags_q) | ev_i;
  end
  assign flags_o = flags_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !clr_i) |=> flags_q[i]) else $error("sticky"); // R2
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (!flags_q[i] && !ev_i[i]) |=> !flags_q[i]) else $error("cause"); // R3
  end
endmodule

// File: rtl/smi_summary.sv
module smi_summary #(
  parameter int N_SRC   = 6,
  parameter int DATA_W  = 16,
  parameter int SUM_BIT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  ev_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] top_stat_o,
  output logic              smi_o
);
  logic sum_q;

  always_ff @(posedge clk) begin
    if (rst)        sum_q <= 1'b0;
    else if (clr_i) sum_q <= |ev_i;
    else            sum_q <= sum_q | (|ev_i);
  end

  always_comb begin
    top_stat_o = '0;
    top_stat_o[SUM_BIT] = sum_q;
  end
  assign smi_o = sum_q;
endmodule

// File: rtl/smi_rd_port.sv
module smi_rd_port #(
  parameter int N_SRC  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [N_SRC-1:0]  flags_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int RSV_W = DATA_W - N_SRC;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (rd_en_i) rd_q <= {{RSV_W{1'b0}}, flags_i};
  end
  assign rd_data_o = rd_q;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_q[DATA_W-1:N_SRC] == '0) else $error("rsv"); // R1
endmodule

// File: rtl/smi_status_agg.sv
module smi_status_agg
  import smi_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TMR-1:0]  tmr_expire_i,
  input  logic [N_TMR-1:0]  tmr_en_i,
  input  logic [N_DEV-1:0]  dev_trap_i,
  input  logic [N_DEV-1:0]  dev_en_i,
  input  logic [N_FUNC-1:0] func_trap_i,
  input  logic [N_FUNC-1:0] func_en_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] top_stat_o,
  output logic              smi_o
);
  logic [N_SRC-1:0] ev;
  logic [N_SRC-1:0] flags;
  logic             clr;

  assign clr = rd_en_i && (addr_i == ADDR_CLR);

  smi_src_gate #(.N_TMR(N_TMR), .N_DEV(N_DEV), .N_FUNC(N_FUNC)) u_gate (
    .tmr_expire_i(tmr_expire_i), .tmr_en_i(tmr_en_i),
    .dev_trap_i(dev_trap_i), .dev_en_i(dev_en_i),
    .func_trap_i(func_trap_i), .func_en_i(func_en_i),
    .ev_o(ev)
  );

  smi_flag_reg #(.N_SRC(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .ev_i(ev), .clr_i(clr), .flags_o(flags)
  );

  smi_summary #(.N_SRC(N_SRC), .DATA_W(DATA_W), .SUM_BIT(SUM_BIT)) u_sum (
    .clk(clk), .rst(rst), .ev_i(ev), .clr_i(clr),
    .top_stat_o(top_stat_o), .smi_o(smi_o)
  );

  smi_rd_port #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .flags_i(flags),
    .rd_data_o(rd_data_o)
  );

  AST_SMI_MATCH: assert property (@(posedge clk) disable iff (rst)
    smi_o == (|flags)) else $error("smi"); // R5
  AST_RD_VALUE: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_data_o[N_SRC-1:0] == $past(flags)) else $error("rd"); // R7
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && ev == '0) |=> (flags == '0 && !smi_o)) else $error("clr"); // R6
  AST_KEEP_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (clr && ev != '0) |=> (smi_o && flags == $past(ev))) else $error("hit"); // R8
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !rd_en_i && ev == '0 && (wr_data_i != '0 || addr_i == ADDR_CLR))
      |=> $stable(flags)) else $error("wr"); // R9
  AST_TMR_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> $past(tmr_en_i[0])) else $error("gate"); // R3
endmodule

// File: tb/tb_smi_status_agg.sv
module tb_smi_status_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  tmr_expire_i = '0, tmr_en_i = '0;
  logic [2:0]  dev_trap_i = '0, dev_en_i = '0;
  logic [5:0]  func_trap_i = '0, func_en_i = '0;
  logic        rd_en_i = 1'b0, wr_en_i = 1'b0, addr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o, top_stat_o;
  logic        smi_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [5:0]  m_flags = '0;
  logic [15:0] m_rd = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  smi_status_agg dut (
    .clk(clk), .rst(rst), .tmr_expire_i(tmr_expire_i), .tmr_en_i(tmr_en_i),
    .dev_trap_i(dev_trap_i), .dev_en_i(dev_en_i), .func_trap_i(func_trap_i),
    .func_en_i(func_en_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .top_stat_o(top_stat_o),
    .smi_o(smi_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] gated();
    logic [5:0] e;
    e[1:0] = tmr_expire_i & tmr_en_i;
    e[4:2] = dev_trap_i & dev_en_i;
    e[5]   = |(func_trap_i & func_en_i);
    return e;
  endfunction

  // Inputs are already driven; clock once, update the model, compare.
  task automatic step(input string tag);
    logic [5:0] e;
    logic [5:0] old;
    e   = gated();
    old = m_flags;
    @(posedge clk);
    #1;
    if (rd_en_i) m_rd = {10'b0, old};
    m_flags = ((rd_en_i && addr_i == 1'b0) ? 6'b0 : old) | e;
    check({tag, " rd_data"}, rd_data_o, m_rd);
    check({tag, " top_stat"}, top_stat_o, (m_flags != 0) ? 16'h0200 : 16'h0000);
    check({tag, " smi"}, {15'b0, smi_o}, {15'b0, m_flags != 0});
    check("R1 reserved", {6'b0, rd_data_o[15:6]}, 16'h0);
    tmr_expire_i = '0; dev_trap_i = '0; func_trap_i = '0;
    rd_en_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic do_read(input logic a, input string tag);
    rd_en_i = 1'b1; addr_i = a;
    step(tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 rd_data", rd_data_o, 16'h0);
    check("R10 top_stat", top_stat_o, 16'h0);
    check("R10 smi", {15'b0, smi_o}, 16'h0);
    rst = 1'b0;

    // R2 / R3 / R1: each single source with enable off and on
    for (int s = 0; s < 6; s++) begin
      for (int en = 0; en < 2; en++) begin
        tmr_en_i = '0; dev_en_i = '0; func_en_i = '0;
        if (s < 2) begin tmr_expire_i[s] = 1'b1; tmr_en_i[s] = en[0]; end
        else if (s < 5) begin dev_trap_i[s-2] = 1'b1; dev_en_i[s-2] = en[0]; end
        else begin func_trap_i[3] = 1'b1; func_en_i[3] = en[0]; end
        step(en ? "R2 enabled event" : "R3 disabled event");
        step("R2 held");
        do_read(1'b1, "R7 mirror read");
        check("R1 bit position", rd_data_o, en ? (16'h1 << s) : 16'h0);
        step("R7 still set");
        do_read(1'b0, "R6 clearing read");
        check("R6 read value", rd_data_o, en ? (16'h1 << s) : 16'h0);
        do_read(1'b0, "R6 cleared");
      end
    end

    // R4: every function trap / enable combination
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        func_trap_i = a[5:0]; func_en_i = b[5:0];
        step("R4 func trap");
        do_read(1'b0, "R4 clear");
      end
    end

    // R8: event during clearing read
    tmr_en_i = 2'b11; dev_en_i = 3'b111; func_en_i = '1;
    dev_trap_i = 3'b101; step("R8 setup");
    tmr_expire_i = 2'b10; do_read(1'b0, "R8 collide");
    check("R8 read excludes new", rd_data_o, 16'h0014);
    do_read(1'b1, "R8 kept");
    check("R8 kept value", rd_data_o, 16'h0002);
    do_read(1'b0, "R8 drain");

    // R9: writes at both addresses with varied data
    dev_trap_i = 3'b010; step("R9 setup");
    for (int w = 0; w < 32; w++) begin
      wr_en_i = 1'b1; addr_i = w[0]; wr_data_i = 16'hFFFF ^ (16'(w) * 16'h1357);
      step("R9 write ignored");
    end
    do_read(1'b1, "R9 check");
    check("R9 flags after writes", rd_data_o, 16'h0008);
    do_read(1'b0, "R9 drain");

    // R5 / R8: pseudo-random mixed traffic
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tmr_expire_i = lfsr[1:0] & {2{lfsr[20]}};
      tmr_en_i     = lfsr[3:2];
      dev_trap_i   = lfsr[6:4] & {3{lfsr[21]}};
      dev_en_i     = lfsr[9:7];
      func_trap_i  = lfsr[15:10] & {6{lfsr[22]}};
      func_en_i    = lfsr[29:24];
      rd_en_i      = lfsr[16] & lfsr[23];
      addr_i       = lfsr[17];
      wr_en_i      = lfsr[18];
      wr_data_i    = lfsr[31:16];
      step("R5 mixed traffic");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule